// File: doc/BRIEF.md
# Fall-Through Marker FIFO

This block is a first-in first-out store of sixteen 4-bit words. Each storage stage has a valid marker. A word moves toward the output stage one stage per clock while the stage ahead of it is empty. Flow is controlled only by these markers, so the block has no read or write pointers. A word written into an empty FIFO therefore arrives at the output on its own after a fixed number of clocks. The producer and the consumer never share an address.

The producer raises `shift_in` while `in_rdy` is high, and the word on `din` is captured on the clock where the strobe is first seen high. The consumer watches `out_rdy` and takes the word on `dout` by pulling `shift_out` low. `out_dis` blocks unloading and drops `dout_en`, which models a bus driver that can be switched off. `mstr_clr` asynchronously marks every stage empty and leaves the stored words in place. `rst_n` is the chip reset, which also resets the strobe history.

Top module: `fallthru_fifo`

## Requirements
- R1: After `rst_n` is released with no activity, `out_rdy` is 0 and `in_rdy` is 1.
- R2: A word is captured only on a clock where `shift_in` is 1 and was 0 on the previous clock, and only while `in_rdy` is 1. Holding `shift_in` high captures nothing further.
- R3: In the cycle after a capture into an empty first stage, `in_rdy` is 0. It returns to 1 one clock later, once the word has passed to the second stage.
- R4: A word captured into an empty FIFO moves one stage per clock. `out_rdy` rises 15 clocks after the capture edge, with that word on `dout`.
- R5: Once all 16 stages hold words, `in_rdy` stays 0 and further `shift_in` pulses are ignored.
- R6: A clock that samples `shift_out` low after sampling it high, with `out_rdy` 1 and `out_dis` 0, removes the output word. `out_rdy` is 0 in the next cycle, and it rises again when the next word arrives.
- R7: While the FIFO is empty, `shift_out` pulses are ignored and do not affect later words.
- R8: While `out_dis` is 1, no word is removed and `out_rdy` stays 1 if it was 1.
- R9: If `out_dis` is sampled 0 after being sampled 1 while `shift_out` is sampled 0, the output word is removed on that clock.
- R10: `dout_en` is the inverse of `out_dis`. `dout` always shows the word held in the last stage.
- R11: While `mstr_clr` is 1, `out_rdy` is 0 and `in_rdy` is 1 without waiting for a clock. The word on `dout` is kept, and the words lost in this way never reach the output.
- R12: A capture and a removal that fall on the same clock both take effect.
- R13: Words leave in the order they were captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| mstr_clr | input | 1 | Asynchronous active-high marker clear |
| shift_in | input | 1 | Load strobe, acts on its rise |
| din | input | 4 | Word to load |
| in_rdy | output | 1 | First stage is free |
| shift_out | input | 1 | Unload strobe, acts on its fall |
| out_dis | input | 1 | Blocks unloading and disables the data output |
| out_rdy | output | 1 | Last stage holds a valid word |
| dout | output | 4 | Word in the last stage |
| dout_en | output | 1 | Output driver enable |

## Verification
The assertions assume that the strobes and `out_dis` change away from the rising clock edge. They also assume that `mstr_clr` is applied asynchronously and held across at least one edge, and that a strobe level lasts at least one clock, so every transition is sampled. The stimulus changes every input on the falling clock edge and never toggles a strobe twice within one period. The bench applies `mstr_clr` mid-cycle on purpose, to observe its asynchronous effect before the next clock.

// File: rtl/fallthru_pkg.sv
package fallthru_pkg;

  // Marker update shared by every stage: an occupied stage empties only when
  // the place ahead is free; an empty stage takes whatever its feeder offers.
  function automatic logic marker_next(input logic own, input logic feed, input logic ahead_busy);
    return own ? ahead_busy : feed;
  endfunction

endpackage

// File: rtl/ft_strobe_hist.sv
module ft_strobe_hist #(
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic prev
);

  logic prev_nxt;

  always_comb begin
    prev_nxt = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_LVL;
    else        prev <= prev_nxt;
  end

endmodule

// File: rtl/ft_stage.sv
module ft_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclr,
  input  logic             feed_v,
  input  logic [WIDTH-1:0] feed_d,
  input  logic             ahead_busy,
  output logic             own_v,
  output logic [WIDTH-1:0] own_d
);
  import fallthru_pkg::*;

  logic v_nxt;
  logic take;

  always_comb begin
    take  = !own_v && feed_v;
    v_nxt = marker_next(own_v, feed_v, ahead_busy);
  end

  always_ff @(posedge clk or negedge rst_n or posedge mclr) begin
    if (!rst_n)    own_v <= 1'b0;
    else if (mclr) own_v <= 1'b0;
    else           own_v <= v_nxt;
  end

  // data carries no reset: a clear only withdraws the marker
  always_ff @(posedge clk) begin
    if (take) own_d <= feed_d;
  end

  // R13
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    own_v && ahead_busy |=> own_v && $stable(own_d));

  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    !own_v && !feed_v |=> !own_v);

endmodule

// File: rtl/fallthru_fifo.sv
module fallthru_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mstr_clr,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy,
  input  logic             shift_out,
  input  logic             out_dis,
  output logic             out_rdy,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0]            mark;
  logic [DEPTH-1:0][WIDTH-1:0] word;
  logic [DEPTH-1:0]            feed_v;
  logic [DEPTH-1:0][WIDTH-1:0] feed_d;
  logic [DEPTH-1:0]            ahead;

  logic sin_prev, sout_prev, dis_prev;
  logic load_go, unload_go;

  ft_strobe_hist #(.RST_LVL(1'b1)) u_sin_hist (
    .clk(clk), .rst_n(rst_n), .lvl(shift_in), .prev(sin_prev));
  ft_strobe_hist #(.RST_LVL(1'b0)) u_sout_hist (
    .clk(clk), .rst_n(rst_n), .lvl(shift_out), .prev(sout_prev));
  ft_strobe_hist #(.RST_LVL(1'b0)) u_dis_hist (
    .clk(clk), .rst_n(rst_n), .lvl(out_dis), .prev(dis_prev));

  always_comb begin
    load_go   = shift_in && !sin_prev;
    // fall of shift_out, or enable returning while shift_out already low
    unload_go = !shift_out && !out_dis && (sout_prev || dis_prev) && mark[LAST];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_chain
    if (g == 0) begin : g_head
      assign feed_v[g] = load_go;
      assign feed_d[g] = din;
    end else begin : g_body
      assign feed_v[g] = mark[g-1];
      assign feed_d[g] = word[g-1];
    end
    if (g == LAST) begin : g_tail
      assign ahead[g] = !unload_go;
    end else begin : g_mid
      assign ahead[g] = mark[g+1];
    end
    ft_stage #(.WIDTH(WIDTH)) u_stage (
      .clk(clk), .rst_n(rst_n), .mclr(mstr_clr),
      .feed_v(feed_v[g]), .feed_d(feed_d[g]), .ahead_busy(ahead[g]),
      .own_v(mark[g]), .own_d(word[g]));
  end

  always_comb begin
    in_rdy  = !mark[0];
    out_rdy = mark[LAST];
    dout    = word[LAST];
    dout_en = !out_dis;
  end

  // R3
  capture_drops_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n || mstr_clr)
    load_go && in_rdy |=> !in_rdy);

  // R6
  unload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n || mstr_clr)
    unload_go |=> !out_rdy);

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || mstr_clr)
    out_dis && out_rdy |=> out_rdy);

  // R5
  full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n || mstr_clr)
    (&mark) |=> !in_rdy);

  // R11
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mstr_clr |-> !out_rdy && in_rdy);

endmodule

// File: tb/fallthru_fifo_tb.sv
`timescale 1ns/1ps
module fallthru_fifo_tb;

  logic       clk = 1'b0;
  logic       rst_n, mclr, sin, sout, odis;
  logic [3:0] din;
  logic       in_rdy, out_rdy, dout_en;
  logic [3:0] dout;

  always #2 clk = ~clk;

  fallthru_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .mstr_clr(mclr), .shift_in(sin), .din(din),
    .in_rdy(in_rdy), .shift_out(sout), .out_dis(odis), .out_rdy(out_rdy),
    .dout(dout), .dout_en(dout_en));

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string phase = "R1";

  // behavioural model: queue of words with their place (0 = entry, 15 = exit)
  int         pos_q[$];
  logic [3:0] dat_q[$];
  bit         m_sin_p, m_sout_p, m_odis_p;
  logic [3:0] m_out;
  bit         m_known = 0;

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit slot0, at15, ld, ul;
    int old[$];
    if (!rst_n) begin
      pos_q.delete(); dat_q.delete();
      m_sin_p = 1; m_sout_p = 0; m_odis_p = 0;
      return;
    end
    slot0 = 1;
    foreach (pos_q[i]) if (pos_q[i] == 0) slot0 = 0;
    at15 = (pos_q.size() > 0) && (pos_q[0] == 15);
    ld = sin && !m_sin_p && slot0 && !mclr;
    ul = !sout && !odis && (m_sout_p || m_odis_p) && at15 && !mclr;
    m_sin_p = sin; m_sout_p = sout; m_odis_p = odis;
    if (mclr) begin
      pos_q.delete(); dat_q.delete();
      return;
    end
    old = pos_q;
    foreach (pos_q[i]) begin
      if (i == 0) begin
        if (old[0] < 15) pos_q[0]++;
      end else if (old[i] < 15 && old[i-1] != old[i] + 1) begin
        pos_q[i]++;
      end
      if (pos_q[i] == 15 && old[i] != 15) begin
        m_out = dat_q[i]; m_known = 1;
      end
    end
    if (ul) begin
      void'(pos_q.pop_front()); void'(dat_q.pop_front());
    end
    if (ld) begin
      pos_q.push_back(0); dat_q.push_back(din);
    end
  endtask

  task automatic compare();
    bit e_dir, e_dor;
    e_dir = 1; e_dor = 0;
    foreach (pos_q[i]) begin
      if (pos_q[i] == 0)  e_dir = 0;
      if (pos_q[i] == 15) e_dor = 1;
    end
    chk(phase, "in_rdy", in_rdy, e_dir);
    chk(phase, "out_rdy", out_rdy, e_dor);
    chk("R10", "dout_en", dout_en, !odis);
    if (m_known) chk(phase, "dout", dout, m_out);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wait_dor();
    for (int n = 0; n < 40 && !out_rdy; n++) tick();
  endtask

  task automatic wait_dir();
    for (int n = 0; n < 40 && !in_rdy; n++) tick();
  endtask

  task automatic pulse_in(logic [3:0] w);
    din = w; sin = 1; tick();
    sin = 0; tick();
  endtask

  task automatic pulse_out();
    sout = 1; tick();
    sout = 0; tick();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    rst_n = 0; mclr = 0; sin = 0; sout = 0; odis = 0; din = 0;
    repeat (3) @(posedge clk);
    model_step();
    @(negedge clk);
    rst_n = 1;
    tick(); tick();
    chk("R1", "out_rdy", out_rdy, 0);
    chk("R1", "in_rdy", in_rdy, 1);

    // single word, strobe left high: one capture only
    phase = "R4";
    din = 4'hA; sin = 1; tick();
    chk("R3", "in_rdy after capture", in_rdy, 0);
    tick();
    chk("R3", "in_rdy after pass", in_rdy, 1);
    repeat (13) tick();
    chk("R4", "out_rdy at 14", out_rdy, 0);
    tick();
    chk("R4", "out_rdy at 15", out_rdy, 1);
    chk("R4", "dout", dout, 4'hA);
    phase = "R6";
    pulse_out();
    chk("R6", "out_rdy after unload", out_rdy, 0);
    repeat (20) tick();
    chk("R2", "no second capture", out_rdy, 0);
    sin = 0; tick();

    // empty: unload strobes ignored
    phase = "R7";
    pulse_out(); pulse_out();
    chk("R7", "out_rdy empty", out_rdy, 0);

    // fill to 16
    phase = "R5";
    for (int k = 0; k < 16; k++) begin
      wait_dir();
      pulse_in(k[3:0]);
    end
    repeat (30) tick();
    chk("R5", "in_rdy when full", in_rdy, 0);
    pulse_in(4'h9);
    chk("R5", "in_rdy after rejected pulse", in_rdy, 0);

    phase = "R13";
    for (int k = 0; k < 16; k++) begin
      wait_dor();
      chk("R13", "order", dout, k);
      pulse_out();
    end
    repeat (20) tick();
    chk("R5", "rejected word absent", out_rdy, 0);
    pulse_out();
    chk("R7", "out_rdy stays low", out_rdy, 0);
    chk("R7", "in_rdy high", in_rdy, 1);

    // simultaneous load and unload
    phase = "R12";
    pulse_in(4'h3);
    wait_dor();
    pulse_in(4'h4);
    wait_dir();
    sout = 1; tick();
    din = 4'h7; sin = 1; sout = 0; tick();
    chk("R12", "unload taken", out_rdy, 0);
    chk("R12", "load taken", in_rdy, 0);
    sin = 0;
    wait_dor();
    chk("R12", "next word", dout, 4'h4);
    pulse_out();
    wait_dor();
    chk("R12", "loaded word", dout, 4'h7);
    pulse_out();
    repeat (3) tick();

    // output disable and its release hazard
    phase = "R8";
    pulse_in(4'hC);
    wait_dor();
    odis = 1; tick();
    chk("R10", "dout_en off", dout_en, 0);
    pulse_out();
    repeat (3) tick();
    chk("R8", "held while disabled", out_rdy, 1);
    phase = "R9";
    odis = 0; tick();
    chk("R9", "unload on enable", out_rdy, 0);
    chk("R10", "dout_en on", dout_en, 1);
    repeat (3) tick();

    // master clear mid-cycle
    phase = "R11";
    pulse_in(4'h5);
    wait_dor();
    pulse_in(4'h6);
    repeat (3) tick();
    mclr = 1;
    pos_q.delete(); dat_q.delete();
    #1;
    chk("R11", "out_rdy async", out_rdy, 0);
    chk("R11", "in_rdy async", in_rdy, 1);
    chk("R11", "dout kept", dout, 4'h5);
    tick(); tick();
    mclr = 0; tick();
    pulse_in(4'hE);
    wait_dor();
    chk("R11", "new word after clear", dout, 4'hE);
    pulse_out();
    repeat (20) tick();
    chk("R11", "cleared word gone", out_rdy, 0);

    summary();
  end

endmodule